// File: doc/BRIEF.md
# Multi-Channel DRAM Address Interleave Decoder

This block takes a physical byte address and splits it into the channel, rank, bank, row and column at which the access lands in a multi-channel DRAM system. The bits that select a byte inside one DRAM burst are dropped first. What remains names exactly one burst location. A two-bit mode input picks, per request, one of three bit orders. In the first order the whole column sits below the channel. In the other two the column is split: its low part sits beneath the channel bits and its high part sits above them. The size of the low part follows from how many bursts fit into one channel stripe. Sequential bursts inside one stripe therefore walk consecutive columns before the address moves to the next channel.

Every geometry value is a power-of-two parameter, so each divide and modulo becomes a fixed bit slice. For each accepted request the block also checks whether the parameters suit the chosen mode. A request that breaks a rule yields a registered error flag instead of a valid decode. Decoded fields appear one clock after the request.

Top module: `dram_ilv_decoder`

## Requirements
- R1: The low address bits that select a byte inside one burst have no effect on any decoded field. With the default geometry these are bits [4:0], since a burst is 4 devices × 8 beats × 8 bits ÷ 8 = 32 bytes.
- R2: Mode 0 decodes the following fields, counting up from the burst offset: the full column (log2 of columns per row buffer bits), then the channel, bank, rank and row.
- R3: Mode 1 decodes the following fields, counting up from the burst offset: the low column (log2 of columns per stripe bits), then the channel, the high column (log2 of columns-per-row ÷ columns-per-stripe bits), and then the bank, rank and row.
- R4: Mode 2 decodes the following fields, counting up from the burst offset: the low column, then the channel, bank, rank, high column and row.
- R5: In modes 1 and 2, the output column equals the high column bits placed directly above the low column bits.
- R6: The row is the remaining value modulo rows per bank. Address bits above the row field have no effect.
- R7: Mode 0 reports a configuration error unless the stripe granularity equals the row buffer size.
- R8: Mode value 3 is reserved and always reports a configuration error.
- R9: Modes 1 and 2 report a configuration error if the stripe granularity is smaller than the cache line or burst, or larger than the row buffer. Every mode reports a configuration error if the channel count differs from the number of address stripes.
- R10: out_valid is high exactly one cycle after a request that was valid and error-free. out_cfg_err is high exactly one cycle after a valid request that broke a rule. The two are never high together.
- R11: The decoded field outputs hold their values unless a valid, error-free request was accepted in the previous cycle.
- R12: While reset is applied, out_valid, out_cfg_err and all field outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe |
| in_addr | input | ADDR_W | Physical byte address |
| in_mode | input | 2 | Bit-order mode: 0, 1, 2; 3 is reserved |
| out_valid | output | 1 | Decoded fields are valid |
| out_cfg_err | output | 1 | The previous request broke a configuration rule |
| out_channel | output | CH_OW | Channel index |
| out_rank | output | RK_OW | Rank index |
| out_bank | output | BK_OW | Bank index |
| out_row | output | ROW_OW | Row index |
| out_column | output | COL_OW | Column index, counted in bursts |

## Verification
The configuration rules depend on elaboration parameters, so one instance can only reach a few of the error cases through its mode input. The bench therefore builds four copies side by side:
- the default geometry;
- one whose stripe equals the row buffer, so mode 0 decodes;
- one whose stripe is below the cache line;
- one whose stripe count differs from its channel count.

All four receive the same request stream, and each is compared on every clock against a divide-and-modulo model. The split-column case of R5 is hardest to hit by chance, so directed addresses set only the low column bit and only the bit just above the channel.

// File: rtl/dram_ilv_pkg.sv
package dram_ilv_pkg;

  typedef enum logic [1:0] {
    MAP_COL_BELOW_CH  = 2'd0,
    MAP_SPLIT_COL     = 2'd1,
    MAP_SPLIT_COL_TOP = 2'd2,
    MAP_RESERVED      = 2'd3
  } map_mode_e;

  // extract w bits of v starting at bit off (w may be zero)
  function automatic logic [63:0] take_bits(input logic [63:0] v,
                                            input int unsigned off,
                                            input int unsigned w);
    logic [63:0] mask;
    if (w == 0)       mask = 64'd0;
    else if (w >= 64) mask = '1;
    else              mask = (64'd1 << w) - 64'd1;
    return (v >> off) & mask;
  endfunction

endpackage

// File: rtl/dram_ilv_cfg_check.sv
module dram_ilv_cfg_check
  import dram_ilv_pkg::*;
#(
  parameter int unsigned BURST_B     = 32,
  parameter int unsigned ROW_BUF_B   = 1024,
  parameter int unsigned STRIPE_B    = 64,
  parameter int unsigned LINE_B      = 64,
  parameter int unsigned CHANNELS    = 2,
  parameter int unsigned NUM_STRIPES = 2
) (
  input  map_mode_e mode,
  output logic      cfg_bad
);
  localparam bit BAD_COUNT = (CHANNELS != NUM_STRIPES);
  localparam bit BAD_ABOVE = (STRIPE_B != ROW_BUF_B);
  localparam bit BAD_LOW   = (STRIPE_B < LINE_B) || (STRIPE_B < BURST_B) ||
                             (STRIPE_B > ROW_BUF_B);

  always_comb begin
    unique case (mode)
      MAP_COL_BELOW_CH:  cfg_bad = BAD_COUNT | BAD_ABOVE;
      MAP_SPLIT_COL:     cfg_bad = BAD_COUNT | BAD_LOW;
      MAP_SPLIT_COL_TOP: cfg_bad = BAD_COUNT | BAD_LOW;
      default:           cfg_bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/dram_ilv_field_map.sv
module dram_ilv_field_map
  import dram_ilv_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BURST_B   = 32,
  parameter int unsigned ROW_BUF_B = 1024,
  parameter int unsigned STRIPE_B  = 64,
  parameter int unsigned CHANNELS  = 2,
  parameter int unsigned RANKS     = 2,
  parameter int unsigned BANKS     = 8,
  parameter int unsigned ROWS      = 4096,
  parameter int unsigned CH_OW     = 1,
  parameter int unsigned RK_OW     = 1,
  parameter int unsigned BK_OW     = 3,
  parameter int unsigned ROW_OW    = 12,
  parameter int unsigned COL_OW    = 5
) (
  input  logic [ADDR_W-1:0]  addr,
  input  map_mode_e          mode,
  output logic [CH_OW-1:0]   channel,
  output logic [RK_OW-1:0]   rank,
  output logic [BK_OW-1:0]   bank,
  output logic [ROW_OW-1:0]  row,
  output logic [COL_OW-1:0]  column
);
  localparam int unsigned OFF  = $clog2(BURST_B);
  localparam int unsigned CB   = $clog2(ROW_BUF_B / BURST_B);
  localparam int unsigned LCR  = (STRIPE_B >= BURST_B) ? $clog2(STRIPE_B / BURST_B) : 0;
  localparam int unsigned LC   = (LCR > CB) ? CB : LCR;
  localparam int unsigned HC   = CB - LC;
  localparam int unsigned CHB  = $clog2(CHANNELS);
  localparam int unsigned BKB  = $clog2(BANKS);
  localparam int unsigned RKB  = $clog2(RANKS);
  localparam int unsigned RWB  = $clog2(ROWS);

  // mode 0 field positions
  localparam int unsigned M0_CH = OFF + CB;
  localparam int unsigned M0_BK = M0_CH + CHB;
  localparam int unsigned M0_RK = M0_BK + BKB;
  localparam int unsigned M0_RW = M0_RK + RKB;
  // mode 1 field positions
  localparam int unsigned M1_CH = OFF + LC;
  localparam int unsigned M1_HI = M1_CH + CHB;
  localparam int unsigned M1_BK = M1_HI + HC;
  localparam int unsigned M1_RK = M1_BK + BKB;
  localparam int unsigned M1_RW = M1_RK + RKB;
  // mode 2 field positions
  localparam int unsigned M2_CH = OFF + LC;
  localparam int unsigned M2_BK = M2_CH + CHB;
  localparam int unsigned M2_RK = M2_BK + BKB;
  localparam int unsigned M2_HI = M2_RK + RKB;
  localparam int unsigned M2_RW = M2_HI + HC;

  logic [63:0] a64;
  logic [63:0] lo_col, hi_col;
  assign a64 = 64'(addr);

  always_comb begin
    lo_col  = take_bits(a64, OFF, LC);
    hi_col  = 64'd0;
    channel = '0;
    rank    = '0;
    bank    = '0;
    row     = '0;
    column  = '0;
    unique case (mode)
      MAP_COL_BELOW_CH: begin
        column  = COL_OW'(take_bits(a64, OFF, CB));
        channel = CH_OW'(take_bits(a64, M0_CH, CHB));
        bank    = BK_OW'(take_bits(a64, M0_BK, BKB));
        rank    = RK_OW'(take_bits(a64, M0_RK, RKB));
        row     = ROW_OW'(take_bits(a64, M0_RW, RWB));
      end
      MAP_SPLIT_COL: begin
        channel = CH_OW'(take_bits(a64, M1_CH, CHB));
        hi_col  = take_bits(a64, M1_HI, HC);
        bank    = BK_OW'(take_bits(a64, M1_BK, BKB));
        rank    = RK_OW'(take_bits(a64, M1_RK, RKB));
        row     = ROW_OW'(take_bits(a64, M1_RW, RWB));
        column  = COL_OW'((hi_col << LC) | lo_col);
      end
      MAP_SPLIT_COL_TOP: begin
        channel = CH_OW'(take_bits(a64, M2_CH, CHB));
        bank    = BK_OW'(take_bits(a64, M2_BK, BKB));
        rank    = RK_OW'(take_bits(a64, M2_RK, RKB));
        hi_col  = take_bits(a64, M2_HI, HC);
        row     = ROW_OW'(take_bits(a64, M2_RW, RWB));
        column  = COL_OW'((hi_col << LC) | lo_col);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dram_ilv_decoder.sv
module dram_ilv_decoder
  import dram_ilv_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned DEV_PER_RANK = 4,
  parameter int unsigned BURST_LEN    = 8,
  parameter int unsigned DEV_BUS_W    = 8,
  parameter int unsigned ROW_BUF_B    = 1024,
  parameter int unsigned STRIPE_B     = 64,
  parameter int unsigned LINE_B       = 64,
  parameter int unsigned CHANNELS     = 2,
  parameter int unsigned NUM_STRIPES  = 2,
  parameter int unsigned RANKS        = 2,
  parameter int unsigned BANKS        = 8,
  parameter int unsigned ROWS         = 4096,
  localparam int unsigned BURST_B = (DEV_PER_RANK * BURST_LEN * DEV_BUS_W) / 8,
  localparam int unsigned CH_OW   = ($clog2(CHANNELS) > 0) ? $clog2(CHANNELS) : 1,
  localparam int unsigned RK_OW   = ($clog2(RANKS) > 0) ? $clog2(RANKS) : 1,
  localparam int unsigned BK_OW   = ($clog2(BANKS) > 0) ? $clog2(BANKS) : 1,
  localparam int unsigned ROW_OW  = ($clog2(ROWS) > 0) ? $clog2(ROWS) : 1,
  localparam int unsigned COL_OW  = ($clog2(ROW_BUF_B / BURST_B) > 0) ?
                                    $clog2(ROW_BUF_B / BURST_B) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  output logic              out_cfg_err,
  output logic [CH_OW-1:0]  out_channel,
  output logic [RK_OW-1:0]  out_rank,
  output logic [BK_OW-1:0]  out_bank,
  output logic [ROW_OW-1:0] out_row,
  output logic [COL_OW-1:0] out_column
);
  // reset synchroniser: asserts at once, releases on the clock
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  map_mode_e   mode;
  logic        cfg_bad;
  logic [CH_OW-1:0]  ch_w;
  logic [RK_OW-1:0]  rk_w;
  logic [BK_OW-1:0]  bk_w;
  logic [ROW_OW-1:0] row_w;
  logic [COL_OW-1:0] col_w;
  assign mode = map_mode_e'(in_mode);

  dram_ilv_cfg_check #(
    .BURST_B(BURST_B), .ROW_BUF_B(ROW_BUF_B), .STRIPE_B(STRIPE_B),
    .LINE_B(LINE_B), .CHANNELS(CHANNELS), .NUM_STRIPES(NUM_STRIPES)
  ) cfg_i (
    .mode(mode), .cfg_bad(cfg_bad)
  );

  dram_ilv_field_map #(
    .ADDR_W(ADDR_W), .BURST_B(BURST_B), .ROW_BUF_B(ROW_BUF_B),
    .STRIPE_B(STRIPE_B), .CHANNELS(CHANNELS), .RANKS(RANKS),
    .BANKS(BANKS), .ROWS(ROWS), .CH_OW(CH_OW), .RK_OW(RK_OW),
    .BK_OW(BK_OW), .ROW_OW(ROW_OW), .COL_OW(COL_OW)
  ) map_i (
    .addr(in_addr), .mode(mode), .channel(ch_w), .rank(rk_w),
    .bank(bk_w), .row(row_w), .column(col_w)
  );

  // next-state logic
  logic load_en;
  logic valid_d, err_d;
  assign load_en = in_valid & ~cfg_bad;
  assign valid_d = in_valid & ~cfg_bad;
  assign err_d   = in_valid & cfg_bad;

  // flag registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid   <= 1'b0;
      out_cfg_err <= 1'b0;
    end else begin
      out_valid   <= valid_d;
      out_cfg_err <= err_d;
    end
  end

  // field registers with explicit enable
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_channel <= '0;
      out_rank    <= '0;
      out_bank    <= '0;
      out_row     <= '0;
      out_column  <= '0;
    end else if (load_en) begin
      out_channel <= ch_w;
      out_rank    <= rk_w;
      out_bank    <= bk_w;
      out_row     <= row_w;
      out_column  <= col_w;
    end
  end

  // R10: flags are mutually exclusive
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_q)
    !(out_valid && out_cfg_err));
  // R10: a clean request yields out_valid next cycle
  p_valid_next_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !cfg_bad) |=> out_valid);
  // R8: reserved mode always flags an error
  p_rsvd_err_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && in_mode == 2'd3) |=> (out_cfg_err && !out_valid));
  // R11: fields hold without a clean request
  p_hold_row_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !(in_valid && !cfg_bad) |=> ($stable(out_row) && $stable(out_column)));
  // R11: bank, rank and channel hold as well
  p_hold_bk_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !(in_valid && !cfg_bad) |=> ($stable(out_bank) && $stable(out_rank) &&
                                 $stable(out_channel)));
  // R10: no output flag without a request
  p_no_req_r10: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> (!out_valid && !out_cfg_err));
endmodule

// File: tb/dram_ilv_decoder_tb.sv
`timescale 1ns/1ps
module dram_ilv_decoder_tb_top;
  localparam int NI = 4;
  localparam longint BURST = 32, ROWBUF = 1024, LINE = 64;
  localparam longint NCH = 2, NBK = 8, NRK = 2, NROW = 4096;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [31:0] in_addr;
  logic [1:0]  in_mode;
  always #10 clk = ~clk;

  logic        ov [NI];
  logic        oe [NI];
  logic [0:0]  och[NI];
  logic [0:0]  ork[NI];
  logic [2:0]  obk[NI];
  logic [11:0] orw[NI];
  logic [4:0]  ocl[NI];

  dram_ilv_decoder dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_addr(in_addr), .in_mode(in_mode), .out_valid(ov[0]), .out_cfg_err(oe[0]),
    .out_channel(och[0]), .out_rank(ork[0]), .out_bank(obk[0]), .out_row(orw[0]),
    .out_column(ocl[0]));
  dram_ilv_decoder #(.STRIPE_B(1024)) dut_rb_i (.clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_addr(in_addr), .in_mode(in_mode), .out_valid(ov[1]),
    .out_cfg_err(oe[1]), .out_channel(och[1]), .out_rank(ork[1]), .out_bank(obk[1]),
    .out_row(orw[1]), .out_column(ocl[1]));
  dram_ilv_decoder #(.STRIPE_B(32)) dut_sm_i (.clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_addr(in_addr), .in_mode(in_mode), .out_valid(ov[2]),
    .out_cfg_err(oe[2]), .out_channel(och[2]), .out_rank(ork[2]), .out_bank(obk[2]),
    .out_row(orw[2]), .out_column(ocl[2]));
  dram_ilv_decoder #(.NUM_STRIPES(4)) dut_sc_i (.clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_addr(in_addr), .in_mode(in_mode), .out_valid(ov[3]),
    .out_cfg_err(oe[3]), .out_channel(och[3]), .out_rank(ork[3]), .out_bank(obk[3]),
    .out_row(orw[3]), .out_column(ocl[3]));

  longint stripe_of[NI] = '{64, 1024, 32, 64};
  int     nstr_of[NI]   = '{2, 2, 2, 4};

  int total = 0, bad = 0;
  bit     e_v[NI], e_e[NI];
  longint e_ch[NI], e_rk[NI], e_bk[NI], e_rw[NI], e_cl[NI];
  string  e_tag[NI];

  function automatic void ref_dec(input longint unsigned addr, input int md,
      input longint stripe, input int nstr, output bit err,
      output longint ch, output longint rk, output longint bk,
      output longint rw, output longint cl);
    longint unsigned a;
    longint cpr, cps, lo, hi;
    a = addr / BURST;
    cpr = ROWBUF / BURST;
    err = (nstr != NCH) || (md == 3) ||
          (md == 0 && stripe != ROWBUF) ||
          (md != 0 && (stripe < LINE || stripe < BURST || stripe > ROWBUF));
    ch = 0; rk = 0; bk = 0; rw = 0; cl = 0;
    if (err) return;
    cps = stripe / BURST;
    if (md == 0) begin
      cl = a % cpr; a = a / cpr;
      ch = a % NCH; a = a / NCH;
      bk = a % NBK; a = a / NBK;
      rk = a % NRK; a = a / NRK;
      rw = a % NROW;
    end else if (md == 1) begin
      lo = a % cps; a = a / cps;
      ch = a % NCH; a = a / NCH;
      hi = a % (cpr / cps); a = a / (cpr / cps);
      bk = a % NBK; a = a / NBK;
      rk = a % NRK; a = a / NRK;
      rw = a % NROW;
      cl = hi * cps + lo;
    end else begin
      lo = a % cps; a = a / cps;
      ch = a % NCH; a = a / NCH;
      bk = a % NBK; a = a / NBK;
      rk = a % NRK; a = a / NRK;
      hi = a % (cpr / cps); a = a / (cpr / cps);
      rw = a % NROW;
      cl = hi * cps + lo;
    end
  endfunction

  // compare all instances against the held expectation
  task automatic check_all();
    for (int i = 0; i < NI; i++) begin
      total++;
      if (ov[i] !== e_v[i] || oe[i] !== e_e[i] || och[i] !== 1'(e_ch[i]) ||
          ork[i] !== 1'(e_rk[i]) || obk[i] !== 3'(e_bk[i]) ||
          orw[i] !== 12'(e_rw[i]) || ocl[i] !== 5'(e_cl[i])) begin
        bad++;
        $display("FAIL %s inst%0d: got v=%0b e=%0b ch=%0d rk=%0d bk=%0d row=%0d col=%0d exp v=%0b e=%0b ch=%0d rk=%0d bk=%0d row=%0d col=%0d",
          e_tag[i], i, ov[i], oe[i], och[i], ork[i], obk[i], orw[i], ocl[i],
          e_v[i], e_e[i], e_ch[i], e_rk[i], e_bk[i], e_rw[i], e_cl[i]);
      end
    end
  endtask

  // check the previous cycle, then drive a new request at the falling edge
  task automatic step(input bit v, input logic [31:0] a, input logic [1:0] m,
                      input string tag);
    @(negedge clk);
    check_all();
    in_valid = v; in_addr = a; in_mode = m;
    for (int i = 0; i < NI; i++) begin
      bit err;
      longint ch, rk, bk, rw, cl;
      ref_dec(longint'(a), int'(m), stripe_of[i], nstr_of[i], err, ch, rk, bk, rw, cl);
      e_v[i] = v && !err;
      e_e[i] = v && err;
      if (v && !err) begin
        e_ch[i] = ch; e_rk[i] = rk; e_bk[i] = bk; e_rw[i] = rw; e_cl[i] = cl;
      end
      if (tag != "") e_tag[i] = tag;
      else if (!v) e_tag[i] = "R11";
      else if (err) e_tag[i] = (m == 3) ? "R8" : ((m == 0) ? "R7" : "R9");
      else e_tag[i] = (m == 0) ? "R2" : ((m == 1) ? "R3" : "R4");
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_mode = '0;
    for (int i = 0; i < NI; i++) begin
      e_v[i] = 0; e_e[i] = 0; e_ch[i] = 0; e_rk[i] = 0; e_bk[i] = 0;
      e_rw[i] = 0; e_cl[i] = 0; e_tag[i] = "R12";
    end
    repeat (3) @(negedge clk);
    check_all();                       // R12: reset values
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: burst-offset bits ignored
    step(1, 32'h1234_5660, 2'd1, "R1");
    step(1, 32'h1234_567F, 2'd1, "R1");
    step(1, 32'h0000_041F, 2'd0, "R1");
    // R5: low column bit alone, then the bit just above the channel
    step(1, 32'h0000_0020, 2'd1, "R5");
    step(1, 32'h0000_0080, 2'd1, "R5");
    step(1, 32'h0000_0020, 2'd2, "R5");
    step(1, 32'h0000_4000, 2'd2, "R5");
    // R6: bits above the row field ignored
    step(1, 32'h07FF_FFE0, 2'd0, "R6");
    step(1, 32'hFFFF_FFE0, 2'd0, "R6");
    step(1, 32'hF000_0000, 2'd2, "R6");
    // R10: toggling request strobe, R11: idle holds
    step(0, 32'hDEAD_BEEF, 2'd1, "R10");
    step(1, 32'hCAFE_0040, 2'd2, "R10");
    step(0, 32'h0000_0000, 2'd1, "R11");
    step(0, 32'hFFFF_FFFF, 2'd0, "R11");
    // R8 reserved mode, R7 and R9 via the instance set
    step(1, 32'h1111_1111, 2'd3, "R8");
    step(1, 32'h2222_2222, 2'd0, "");
    step(1, 32'h3333_3333, 2'd1, "");
    step(1, 32'h4444_4444, 2'd2, "");
    // random mixture across all modes (R2, R3, R4, R7, R9)
    for (int k = 0; k < 3000; k++)
      step(($urandom % 4) != 0, $urandom, 2'($urandom % 4), "");
    step(0, 32'h0, 2'd0, "R11");
    @(negedge clk);
    check_all();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule